// File: doc/BRIEF.md
# Ternary Min-Max Literal Logic Unit

This block evaluates three-valued logic on a vector of trits. Each trit is carried on two binary wires. One operation select applies to every lane. For each lane it gives the ternary OR, which is the larger of two operands, or the ternary AND, which is the smaller. It can also give a window literal of the first operand, which maps each input level to 2 or 0, or it can pass the first operand through unchanged.

A second path builds a sum-of-products result. It takes one partial function that supplies the level-2 terms and one that supplies the level-1 terms. It caps the level-1 part at 1 and then takes the larger of the two values.

The block has no clock and no state, so outputs follow inputs within one combinational delay. A two-bit pattern that is not a legal trit sets an error flag for the affected lane and forces that lane's result to zero. The other lanes are not affected.

Top module: `tern_logic_unit`

## Requirements
- R1: Trit codes are 2'b00 = 0, 2'b01 = 1 and 2'b10 = 2, and 2'b11 is illegal. Lane i occupies bits [2i+1:2i] of every vector. `op_sel` encodes: 0 = max, 1 = min, 2 = literal-0, 3 = literal-1, 4 = literal-2, 5 = literal-01, 6 = literal-12, 7 = pass.
- R2: With op_sel = 0 and legal operands, each lane of `res_vec` equals max(a, b).
- R3: With op_sel = 1 and legal operands, each lane of `res_vec` equals min(a, b).
- R4: The single-value literals (op_sel 2, 3, 4 for values 0, 1, 2) return 2 when operand a equals that value and 0 otherwise. Operand b has no effect on them.
- R5: Literal-01 (op_sel 5) returns 2 for a in {0,1} and 0 for a = 2. Literal-12 (op_sel 6) returns 0 for a = 0 and 2 for a in {1,2}.
- R6: Pass (op_sel 7) returns operand a unchanged.
- R7: For every legal a, exactly one of literal-0, literal-1 and literal-2 is 2, so their maximum is the constant 2.
- R8: For every legal x: min(x,0)=0, min(x,2)=x, max(x,0)=x and max(x,2)=2.
- R9: Each lane of `sop_vec` equals max(F2, min(1, F1)), where F2 comes from `f2_vec` and F1 from `f1_vec`.
- R10: If operand a or operand b of a lane is 2'b11, the lane's `err_op` bit is 1 and its `res_vec` lane is 2'b00. Lanes with legal codes keep their normal results and have a clear error bit.
- R11: If F2 or F1 of a lane is 2'b11, the lane's `err_sop` bit is 1 and its `sop_vec` lane is 2'b00. Other lanes are not affected.
- R12: No output lane ever carries the code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation applied to every lane |
| a_vec | input | 2*N_TRITS | First operand trits |
| b_vec | input | 2*N_TRITS | Second operand trits (max and min only) |
| f2_vec | input | 2*N_TRITS | Level-2 partial function trits |
| f1_vec | input | 2*N_TRITS | Level-1 partial function trits |
| res_vec | output | 2*N_TRITS | Operation result trits |
| sop_vec | output | 2*N_TRITS | Sum-of-products result trits |
| err_op | output | N_TRITS | Per-lane illegal-operand flag |
| err_sop | output | N_TRITS | Per-lane illegal-partial-function flag |

## Verification
The hardest case to reach is one where an illegal code sits in one lane while the neighbouring lanes hold legal values that produce distinct, nonzero results. Only this case shows that masking is confined to the faulty lane. The bench builds such mixed vectors from the sweep's operand pairs, placing 2'b11 in a single operand of one lane at a time. During the exhaustive sweeps it rotates the operand pairs across lanes, so every lane sees all nine pairs under every operation.

// File: rtl/tern_pkg.sv
// Shared trit codes, operation encoding and helpers for the ternary unit.
// Assumes that the numeric order of legal codes matches the logic level order.
package tern_pkg;
    typedef logic [1:0] trit_t;

    localparam trit_t T_ZERO = 2'b00;
    localparam trit_t T_ONE  = 2'b01;
    localparam trit_t T_TWO  = 2'b10;
    localparam trit_t T_BAD  = 2'b11;

    typedef enum logic [2:0] {
        OP_MAX   = 3'd0,
        OP_MIN   = 3'd1,
        OP_LIT0  = 3'd2,
        OP_LIT1  = 3'd3,
        OP_LIT2  = 3'd4,
        OP_LIT01 = 3'd5,
        OP_LIT12 = 3'd6,
        OP_PASS  = 3'd7
    } tern_op_e;

    // Larger of two legal trits (ternary OR).
    function automatic trit_t trit_max(trit_t x, trit_t y);
        return (x > y) ? x : y;
    endfunction

    // Smaller of two legal trits (ternary AND).
    function automatic trit_t trit_min(trit_t x, trit_t y);
        return (x < y) ? x : y;
    endfunction

    // Two-level literal: 2 when the condition holds, else 0.
    function automatic trit_t trit_lit(logic hit);
        return hit ? T_TWO : T_ZERO;
    endfunction
endpackage

// File: rtl/tern_pair_check.sv
// Flags an illegal code on either of two trit inputs.
// Assumes only 2'b11 is illegal; purely combinational.
module tern_pair_check
    import tern_pkg::*;
(
    input  trit_t x_in,
    input  trit_t y_in,
    output logic  bad
);
    // Raise bad when either input holds the unused code.
    always_comb begin
        bad = (x_in == T_BAD) || (y_in == T_BAD);
    end
endmodule

// File: rtl/tern_lane_op.sv
// One lane of the ternary unit: max, min, literals of operand a, or pass.
// Assumes op is shared by all lanes; an illegal operand zeroes the result.
module tern_lane_op
    import tern_pkg::*;
(
    input  logic [2:0] op,
    input  trit_t      a_in,
    input  trit_t      b_in,
    output trit_t      res,
    output logic       err
);
    trit_t raw;
    logic  bad;

    tern_pair_check u_chk (
        .x_in (a_in),
        .y_in (b_in),
        .bad  (bad)
    );

    // Select the operation result for legal operands.
    always_comb begin
        unique case (tern_op_e'(op))
            OP_MAX:   raw = trit_max(a_in, b_in);
            OP_MIN:   raw = trit_min(a_in, b_in);
            OP_LIT0:  raw = trit_lit(a_in == T_ZERO);
            OP_LIT1:  raw = trit_lit(a_in == T_ONE);
            OP_LIT2:  raw = trit_lit(a_in == T_TWO);
            OP_LIT01: raw = trit_lit(a_in != T_TWO);
            OP_LIT12: raw = trit_lit(a_in != T_ZERO);
            default:  raw = a_in;
        endcase
    end

    // Force the lane to zero and flag it when a code is illegal.
    always_comb begin
        err = bad;
        res = bad ? T_ZERO : raw;
    end
endmodule

// File: rtl/tern_sop_join.sv
// Joins a level-2 and a level-1 partial function: F = max(F2, min(1, F1)).
// Assumes legal codes; an illegal code zeroes the result and sets err.
module tern_sop_join
    import tern_pkg::*;
(
    input  trit_t f2_in,
    input  trit_t f1_in,
    output trit_t sop,
    output logic  err
);
    logic bad;

    tern_pair_check u_chk (
        .x_in (f2_in),
        .y_in (f1_in),
        .bad  (bad)
    );

    // Cap the level-1 part at 1, combine it with the level-2 part, mask errors.
    always_comb begin
        err = bad;
        sop = bad ? T_ZERO : trit_max(f2_in, trit_min(T_ONE, f1_in));
    end
endmodule

// File: rtl/tern_logic_unit.sv
// Vector ternary logic unit: N_TRITS independent lanes of min/max/literal
// operations plus a sum-of-products join. Combinational, with no state.
// Assumes that lane i sits in bits [2i+1:2i] of every vector.
module tern_logic_unit #(
    parameter int N_TRITS = 4
) (
    input  logic [2:0]           op_sel,
    input  logic [2*N_TRITS-1:0] a_vec,
    input  logic [2*N_TRITS-1:0] b_vec,
    input  logic [2*N_TRITS-1:0] f2_vec,
    input  logic [2*N_TRITS-1:0] f1_vec,
    output logic [2*N_TRITS-1:0] res_vec,
    output logic [2*N_TRITS-1:0] sop_vec,
    output logic [N_TRITS-1:0]   err_op,
    output logic [N_TRITS-1:0]   err_sop
);
    localparam int TW = 2;

    // One operation lane and one join lane per trit position.
    for (genvar i = 0; i < N_TRITS; i++) begin : g_lane
        tern_lane_op u_op (
            .op   (op_sel),
            .a_in (a_vec[TW*i +: TW]),
            .b_in (b_vec[TW*i +: TW]),
            .res  (res_vec[TW*i +: TW]),
            .err  (err_op[i])
        );

        tern_sop_join u_sop (
            .f2_in (f2_vec[TW*i +: TW]),
            .f1_in (f1_vec[TW*i +: TW]),
            .sop   (sop_vec[TW*i +: TW]),
            .err   (err_sop[i])
        );
    end
endmodule

// File: rtl/tern_logic_unit_chk.sv
// Property checker for tern_logic_unit, attached by bind. It holds immediate
// checks on settled port values, because the block has no clock.
module tern_logic_unit_chk #(
    parameter int N_TRITS = 4
) (
    input logic [2:0]           op_sel,
    input logic [2*N_TRITS-1:0] a_vec,
    input logic [2*N_TRITS-1:0] b_vec,
    input logic [2*N_TRITS-1:0] f2_vec,
    input logic [2*N_TRITS-1:0] f1_vec,
    input logic [2*N_TRITS-1:0] res_vec,
    input logic [2*N_TRITS-1:0] sop_vec,
    input logic [N_TRITS-1:0]   err_op,
    input logic [N_TRITS-1:0]   err_sop
);
    // Check every lane against its relational properties.
    always_comb begin
        for (int i = 0; i < N_TRITS; i++) begin
            logic [1:0] a, b, f2, r, s;
            a  = a_vec[2*i +: 2];
            b  = b_vec[2*i +: 2];
            f2 = f2_vec[2*i +: 2];
            r  = res_vec[2*i +: 2];
            s  = sop_vec[2*i +: 2];
            AST_ERR_ZEROES_RES: assert (!err_op[i] || r == 2'b00);  // R10
            AST_ERR_ZEROES_SOP: assert (!err_sop[i] || s == 2'b00); // R11
            AST_NO_BAD_OUTPUT: assert (r != 2'b11 && s != 2'b11);   // R12
            if (!err_op[i] && op_sel == 3'd0) begin
                AST_MAX_DOMINATES: assert (r >= a && r >= b && (r == a || r == b)); // R2
            end
            if (!err_op[i] && op_sel == 3'd1) begin
                AST_MIN_BOUNDED: assert (r <= a && r <= b && (r == a || r == b)); // R3
            end
            if (!err_op[i] && op_sel >= 3'd2 && op_sel <= 3'd6) begin
                AST_LIT_TWO_LEVEL: assert (r == 2'b00 || r == 2'b10); // R4
            end
            if (!err_op[i] && op_sel == 3'd7) begin
                AST_PASS_KEEPS_A: assert (r == a); // R6
            end
            if (!err_sop[i]) begin
                AST_SOP_FLOOR: assert (s >= f2 && s <= 2'b10); // R9
            end
        end
    end
endmodule

bind tern_logic_unit tern_logic_unit_chk #(.N_TRITS(N_TRITS)) u_chk (
    .op_sel  (op_sel),
    .a_vec   (a_vec),
    .b_vec   (b_vec),
    .f2_vec  (f2_vec),
    .f1_vec  (f1_vec),
    .res_vec (res_vec),
    .sop_vec (sop_vec),
    .err_op  (err_op),
    .err_sop (err_sop)
);

// File: tb/tern_logic_unit_bench.sv
`timescale 1ns/1ps
// Exhaustive bench: integer reference models for every operation and join.
module tern_logic_unit_bench;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic [2:0]     op_sel;
    logic [2*N-1:0] a_vec, b_vec, f2_vec, f1_vec;
    logic [2*N-1:0] res_vec, sop_vec;
    logic [N-1:0]   err_op, err_sop;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk; // 250 MHz pacing clock

    tern_logic_unit #(.N_TRITS(N)) u_tern_logic_unit (
        .op_sel  (op_sel),
        .a_vec   (a_vec),
        .b_vec   (b_vec),
        .f2_vec  (f2_vec),
        .f1_vec  (f1_vec),
        .res_vec (res_vec),
        .sop_vec (sop_vec),
        .err_op  (err_op),
        .err_sop (err_sop)
    );

    function automatic int ref_op(int op, int a, int b);
        case (op)
            0: return (a > b) ? a : b;
            1: return (a < b) ? a : b;
            2: return (a == 0) ? 2 : 0;
            3: return (a == 1) ? 2 : 0;
            4: return (a == 2) ? 2 : 0;
            5: return (a <= 1) ? 2 : 0;
            6: return (a >= 1) ? 2 : 0;
            default: return a;
        endcase
    endfunction

    function automatic int ref_sop(int f2, int f1);
        int c;
        c = (f1 < 1) ? f1 : 1;
        return (f2 > c) ? f2 : c;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lane(logic [2*N-1:0] v, int i);
        return int'(v[2*i +: 2]);
    endfunction

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: all-zero legal inputs with pass give zero and no errors
        @(negedge clk);
        op_sel = 3'd7; a_vec = '0; b_vec = '0; f2_vec = '0; f1_vec = '0;
        #1;
        chk("R1 res zero", int'(res_vec), 0);
        chk("R1 sop zero", int'(sop_vec), 0);
        chk("R1 no errors", int'({err_op, err_sop}), 0);

        // R2..R6, R8, R12: every op, every pair, rotated across lanes
        for (int op = 0; op < 8; op++) begin
            for (int x = 0; x < 3; x++) begin
                for (int y = 0; y < 3; y++) begin
                    @(negedge clk);
                    op_sel = 3'(op);
                    for (int i = 0; i < N; i++) begin
                        a_vec[2*i +: 2] = 2'((x + i) % 3);
                        b_vec[2*i +: 2] = 2'((y + 2*i) % 3);
                    end
                    #1;
                    for (int i = 0; i < N; i++) begin
                        int ea, eb;
                        ea = (x + i) % 3;
                        eb = (y + 2*i) % 3;
                        case (op)
                            0: chk("R2 max", lane(res_vec, i), ref_op(op, ea, eb));
                            1: chk("R3 min", lane(res_vec, i), ref_op(op, ea, eb));
                            2, 3, 4: chk("R4 literal", lane(res_vec, i), ref_op(op, ea, eb));
                            5, 6: chk("R5 window literal", lane(res_vec, i), ref_op(op, ea, eb));
                            default: chk("R6 pass", lane(res_vec, i), ea);
                        endcase
                        if (op < 2 && (eb == 0 || eb == 2)) begin
                            // R8: constant identities
                            chk("R8 identity", lane(res_vec, i),
                                (op == 0) ? ((eb == 0) ? ea : 2) : ((eb == 0) ? 0 : ea));
                        end
                        if (lane(res_vec, i) == 3) chk("R12 no illegal output", 3, 0);
                    end
                    chk("R10 no error on legal", int'(err_op), 0);
                end
            end
        end

        // R7: exactly one single-value literal is 2
        for (int x = 0; x < 3; x++) begin
            int hits, mx;
            hits = 0; mx = 0;
            for (int op = 2; op <= 4; op++) begin
                @(negedge clk);
                op_sel = 3'(op);
                a_vec = {N{2'(x)}};
                b_vec = '0;
                #1;
                if (lane(res_vec, 0) == 2) hits++;
                if (lane(res_vec, 0) > mx) mx = lane(res_vec, 0);
            end
            chk("R7 full span max", mx, 2);
            chk("R7 single hit", hits, 1);
        end

        // R9: join for all nine pairs, rotated across lanes
        for (int p = 0; p < 3; p++) begin
            for (int q = 0; q < 3; q++) begin
                @(negedge clk);
                for (int i = 0; i < N; i++) begin
                    f2_vec[2*i +: 2] = 2'((p + i) % 3);
                    f1_vec[2*i +: 2] = 2'((q + 2*i) % 3);
                end
                #1;
                for (int i = 0; i < N; i++)
                    chk("R9 sop join", lane(sop_vec, i), ref_sop((p + i) % 3, (q + 2*i) % 3));
                chk("R11 no error on legal", int'(err_sop), 0);
            end
        end

        // R10: illegal a in lane 1, then illegal b in lane 3, other lanes intact
        for (int k = 0; k < 2; k++) begin
            int bad_lane;
            bad_lane = (k == 0) ? 1 : 3;
            @(negedge clk);
            op_sel = 3'd0;
            for (int i = 0; i < N; i++) begin
                a_vec[2*i +: 2] = 2'((i + 1) % 3);
                b_vec[2*i +: 2] = 2'(i % 3);
            end
            if (k == 0) a_vec[2*bad_lane +: 2] = 2'b11;
            else        b_vec[2*bad_lane +: 2] = 2'b11;
            #1;
            chk("R10 err flag", int'(err_op), 1 << bad_lane);
            for (int i = 0; i < N; i++)
                chk("R10 lane result", lane(res_vec, i),
                    (i == bad_lane) ? 0 : ref_op(0, (i + 1) % 3, i % 3));
        end

        // R11: illegal F1 in lane 2 masks only that lane
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            f2_vec[2*i +: 2] = 2'(i % 3);
            f1_vec[2*i +: 2] = 2'b10;
        end
        f1_vec[5:4] = 2'b11;
        #1;
        chk("R11 err flag", int'(err_sop), 4);
        for (int i = 0; i < N; i++)
            chk("R11 lane result", lane(sop_vec, i), (i == 2) ? 0 : ref_sop(i % 3, 2));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule